// File: doc/BRIEF.md
# I2C 16-bit Quasi-Bidirectional Port Expander

This block is an I2C target that controls sixteen quasi-bidirectional port pins. It works from the system clock. SCL and SDA are brought in raw, synchronized and edge-detected inside the block, and SDA is driven back through an open-drain pull-low enable. The 7-bit target address has the fixed upper nibble `0100`, and three strap inputs fill the lower bits, so a bus can carry eight such blocks.

The port holds an output latch. A latch bit of 1 means the pin floats high on its weak pullup and can serve as an input. A latch bit of 0 pulls the pin low. Data always moves in byte pairs: the low byte (bits 7:0) comes first and the high byte (bits 15:8) second. Pairs repeat for as long as the transfer lasts. A write changes the latch only when a whole pair has been acknowledged. Every latch bit written to 1 gets a strong-pullup enable pulse, which ends at the next SCL falling edge. A read returns the pin levels as the pins actually sit, with the latch applied on top.

Top module: `i2c_pio16_expander`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `0100` followed by `strap_i[2:0]` (MSB first, bit 0 is read=1/write=0). On any other address it releases SDA for the ACK slot and for all following bytes until the next start.
- R2: The general call address 0x00 is never acknowledged, and data bytes that follow it leave the latch unchanged.
- R3: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A repeated start restarts address decoding, and the byte-pair position returns to the low byte.
- R4: In a write, the first data byte of a pair goes to latch bits 7:0 and the second to bits 15:8. The latch changes only in the ACK clock of the second byte, and every written byte is acknowledged.
- R5: If a stop or repeated start arrives after only one byte of a pair, the latch keeps the value of the last completed pair.
- R6: Any number of pairs may follow one address, and each completed pair replaces the latch value.
- R7: In a read, the block sends the low byte, then the high byte, and keeps alternating while the master acknowledges. After a master NACK it leaves SDA released.
- R8: Each read byte equals `port_pin_i & port_latch_o` for that byte, sampled at the SCL falling edge before its first bit, so a pin latched low reads 0.
- R9: After reset the latch is all ones, every strong-pullup enable is 0 and SDA is released.
- R10: When a pair commits, `boost_o` equals the new latch value (1 for every pin written high), and it returns to all zeros at the next SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 3 | Low three address bits |
| port_pin_i | input | 16 | Sensed level of each port pin |
| port_latch_o | output | 16 | Output latch: 1 weak high, 0 driven low |
| boost_o | output | 16 | Per-pin strong-pullup enable pulse |

## Verification
The bench sweeps all eight strap settings against all eight target addresses. A decoder that compares the wrong bits, or that answers the general call, would acknowledge where the bus must stay high. It sends an odd number of bytes before a stop and before a repeated start: a design that commits per byte, or that does not reset the pair position on a start, would corrupt the latch or swap the halves. Reads run past several pairs with a final NACK and with pins latched low against a high input. A wrong byte order, a missing mask or a late release would show up as wrong bytes on SDA or SDA held low after the NACK. The strong-pullup pulse is checked inside the commit ACK clock and just after the following SCL fall.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } xp_state_e;
endpackage

// File: rtl/xp_line_sync.sv
module xp_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_last_q, sda_last_q;
  logic scl_now, sda_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[TOP-1:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[TOP-1:0], sda_i};
      scl_last_q <= scl_now;
      sda_last_q <= sda_now;
    end
  end

  assign scl_now    = scl_pipe_q[TOP];
  assign sda_now    = sda_pipe_q[TOP];
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_last_q;
  assign scl_fall_o = ~scl_now & scl_last_q;
  assign start_o    = scl_now & scl_last_q & sda_last_q & ~sda_now;
  assign stop_o     = scl_now & scl_last_q & ~sda_last_q & sda_now;
endmodule

// File: rtl/xp_bus_fsm.sv
module xp_bus_fsm
  import xp_pkg::*;
#(
  parameter logic [3:0] ADDR_HI    = 4'b0100,
  parameter int         PORT_BYTES = 2,
  localparam int        IDX_W      = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output xp_state_e         state_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PORT_BYTES - 1);
  localparam logic [3:0]       BITS_END = 4'(BYTE_W);

  xp_state_e         state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rw_q, rw_n, oe_q, oe_n, mack_q, mack_n;
  logic [IDX_W-1:0]  idx_q, idx_n, idx_inc;
  logic              wr_stb;

  assign idx_inc = (idx_q == LAST_IDX) ? '0 : IDX_W'(idx_q + 1'b1);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    rw_n    = rw_q;
    oe_n    = oe_q;
    idx_n   = idx_q;
    mack_n  = mack_q;
    wr_stb  = 1'b0;
    if (stop_i) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_i) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      idx_n   = '0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_n = 4'(cnt_q + 4'd1);
          end else if (scl_fall_i && cnt_q == BITS_END) begin
            if (sh_q[7:1] == {ADDR_HI, strap_i}) begin
              state_n = ST_ADDR_ACK;
              oe_n    = 1'b1;
              rw_n    = sh_q[0];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_n = '0;
            idx_n = '0;
            if (rw_q) begin
              state_n = ST_RD_DATA;
              sh_n    = rd_byte_i;
              oe_n    = ~rd_byte_i[BYTE_W-1];
            end else begin
              state_n = ST_WR_DATA;
              oe_n    = 1'b0;
            end
          end
        end
        ST_WR_DATA: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_n = 4'(cnt_q + 4'd1);
          end else if (scl_fall_i && cnt_q == BITS_END) begin
            state_n = ST_WR_ACK;
            oe_n    = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_rise_i) begin
            wr_stb = 1'b1;
          end else if (scl_fall_i) begin
            state_n = ST_WR_DATA;
            oe_n    = 1'b0;
            cnt_n   = '0;
            idx_n   = idx_inc;
          end
        end
        ST_RD_DATA: begin
          if (scl_rise_i) begin
            cnt_n = 4'(cnt_q + 4'd1);
          end else if (scl_fall_i) begin
            if (cnt_q == BITS_END) begin
              state_n = ST_RD_ACK;
              oe_n    = 1'b0;
              idx_n   = idx_inc;
            end else begin
              sh_n = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_n = ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_n = ST_RD_DATA;
              cnt_n   = '0;
              sh_n    = rd_byte_i;
              oe_n    = ~rd_byte_i[BYTE_W-1];
            end else begin
              state_n = ST_IDLE;
              oe_n    = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      idx_q   <= '0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
      idx_q   <= idx_n;
      mack_q  <= mack_n;
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_stb_o   = wr_stb;
  assign wr_data_o  = sh_q;
  assign byte_idx_o = idx_q;
  assign state_o    = state_q;

  AST_QUIET_UNADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_ADDR) |-> !sda_oe_o); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE)); // R3
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state_q == ST_ADDR && idx_q == '0)); // R3
  AST_MASTER_ACK_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK) |-> !sda_oe_o); // R7
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BITS_END); // R4
endmodule

// File: rtl/xp_port_bank.sv
module xp_port_bank
  import xp_pkg::*;
#(
  parameter int PORT_BYTES = 2,
  localparam int PORT_W    = PORT_BYTES * BYTE_W,
  localparam int IDX_W     = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_fall_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic [PORT_W-1:0] latch_o,
  output logic [PORT_W-1:0] boost_o
);
  localparam int               LOW_W    = (PORT_BYTES - 1) * BYTE_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PORT_BYTES - 1);

  logic [LOW_W-1:0]  held_low;
  logic [PORT_W-1:0] latch_q, latch_n, boost_q, boost_n, rd_vec;
  logic              commit;

  assign commit = wr_stb_i && (idx_i == LAST_IDX);

  for (genvar g = 0; g < PORT_BYTES - 1; g++) begin : g_hold
    logic [BYTE_W-1:0] hold_q;
    logic              hold_en;
    assign hold_en = wr_stb_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q <= '1;
      end else if (hold_en) begin
        hold_q <= wr_data_i;
      end
    end
    assign held_low[g*BYTE_W +: BYTE_W] = hold_q;
  end

  always_comb begin
    latch_n = latch_q;
    boost_n = boost_q;
    if (commit) begin
      latch_n = {wr_data_i, held_low};
      boost_n = {wr_data_i, held_low};
    end else if (scl_fall_i) begin
      boost_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
      boost_q <= '0;
    end else begin
      latch_q <= latch_n;
      boost_q <= boost_n;
    end
  end

  assign rd_vec = pin_i & latch_q;

  always_comb begin
    rd_byte_o = '0;
    for (int b = 0; b < PORT_BYTES; b++) begin
      if (idx_i == IDX_W'(b)) rd_byte_o = rd_vec[b*BYTE_W +: BYTE_W];
    end
  end

  assign latch_o = latch_q;
  assign boost_o = boost_q;

  AST_BOOST_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_i && !wr_stb_i) |=> (boost_o == '0)); // R10
  AST_HALF_PAIR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && idx_i != LAST_IDX) |=> $stable(latch_o)); // R5
endmodule

// File: rtl/i2c_pio16_expander.sv
module i2c_pio16_expander
  import xp_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b0100,
  parameter int         SYNC_STAGES = 2,
  parameter int         PORT_BYTES  = 2,
  localparam int        PORT_W      = PORT_BYTES * BYTE_W,
  localparam int        IDX_W       = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic [PORT_W-1:0] port_pin_i,
  output logic [PORT_W-1:0] port_latch_o,
  output logic [PORT_W-1:0] boost_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [IDX_W-1:0]  byte_idx;
  xp_state_e         fsm_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  xp_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  xp_bus_fsm #(.ADDR_HI(ADDR_HI), .PORT_BYTES(PORT_BYTES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .strap_i    (strap_i),
    .rd_byte_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .byte_idx_o (byte_idx),
    .state_o    (fsm_state)
  );

  xp_port_bank #(.PORT_BYTES(PORT_BYTES)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .scl_fall_i (scl_fall),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .idx_i      (byte_idx),
    .pin_i      (port_pin_i),
    .rd_byte_o  (rd_byte),
    .latch_o    (port_latch_o),
    .boost_o    (boost_o)
  );

  AST_LATCH_ONLY_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fsm_state != ST_WR_ACK) |=> $stable(port_latch_o)); // R4
  AST_BOOST_IMPLIES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(boost_o != '0) |-> (fsm_state == ST_WR_ACK)); // R10
endmodule

// File: tb/i2c_pio16_expander_bench.sv
module i2c_pio16_expander_bench;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic [2:0]  strap = 3'b000;
  logic [15:0] pins = 16'hFFFF;
  logic [15:0] latch, boost;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_pio16_expander u_i2c_pio16_expander (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .strap_i      (strap),
    .port_pin_i   (pins),
    .port_latch_o (latch),
    .boost_o      (boost)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack, output logic [15:0] bst);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    bst = boost;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    bit_io(~give_ack, r);
  endtask

  task automatic write_pair(input logic [15:0] v, input string req);
    logic a; logic [15:0] b;
    send_byte(v[7:0], a, b);
    chk({req, " low ack"}, {31'd0, a}, 32'd1);
    send_byte(v[15:8], a, b);
    chk({req, " high ack"}, {31'd0, a}, 32'd1);
    chk("R10 boost at commit", {16'd0, b}, {16'd0, v});
    chk({req, " latch"}, {16'd0, latch}, {16'd0, v});
    chk("R10 boost cleared", {16'd0, boost}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic        a;
    logic [15:0] b, v, prev;
    logic [7:0]  d;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    // R9 reset state
    chk("R9 latch", {16'd0, latch}, 32'h0000FFFF);
    chk("R9 boost", {16'd0, boost}, 32'd0);
    chk("R9 sda", {31'd0, sda_oe}, 32'd0);

    // R1 every strap value against every target address
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 8; t++) begin
        strap = 3'(s);
        bus_start();
        send_byte({4'b0100, 3'(t), 1'b0}, a, b);
        bus_stop();
        chk($sformatf("R1 strap=%0d tgt=%0d", s, t), {31'd0, a}, {31'd0, (s == t)});
      end
    end
    strap = 3'b101;

    // R2 general call ignored
    bus_start();
    send_byte(8'h00, a, b);
    chk("R2 gc ack", {31'd0, a}, 32'd0);
    send_byte(8'h12, a, b);
    chk("R2 data ack", {31'd0, a}, 32'd0);
    send_byte(8'h34, a, b);
    bus_stop();
    chk("R2 latch", {16'd0, latch}, 32'h0000FFFF);

    // R4 single pair, latch unchanged after first byte
    bus_start();
    send_byte(8'h4A, a, b);
    chk("R1 own addr ack", {31'd0, a}, 32'd1);
    send_byte(8'h3C, a, b);
    chk("R4 first byte ack", {31'd0, a}, 32'd1);
    chk("R4 no commit after low", {16'd0, latch}, 32'h0000FFFF);
    send_byte(8'hA5, a, b);
    chk("R4 second ack", {31'd0, a}, 32'd1);
    chk("R10 boost bits", {16'd0, b}, 32'h0000A53C);
    chk("R4 latch order", {16'd0, latch}, 32'h0000A53C);
    chk("R10 boost after fall", {16'd0, boost}, 32'd0);
    bus_stop();

    // R6 several pairs in one transfer
    bus_start();
    send_byte(8'h4A, a, b);
    for (int k = 1; k <= 4; k++) begin
      v = 16'(k * 16'h2357) ^ 16'h0F0F;
      write_pair(v, "R6");
    end
    bus_stop();
    prev = v;

    // R5 stop after half a pair
    bus_start();
    send_byte(8'h4A, a, b);
    send_byte(8'h00, a, b);
    bus_stop();
    chk("R5 stop half pair", {16'd0, latch}, {16'd0, prev});

    // R3 repeated start after half a pair resets pair position
    bus_start();
    send_byte(8'h4A, a, b);
    send_byte(8'h11, a, b);
    bus_start();
    send_byte(8'h4A, a, b);
    chk("R3 restart addr ack", {31'd0, a}, 32'd1);
    chk("R5 restart half pair", {16'd0, latch}, {16'd0, prev});
    write_pair(16'h3322, "R3");
    bus_stop();

    // R7/R8 read alternating bytes with masking
    bus_start();
    send_byte(8'h4A, a, b);
    write_pair(16'hF0FF, "R4");
    bus_stop();
    pins = 16'h5AA5;
    bus_start();
    send_byte(8'h4B, a, b);
    chk("R7 read addr ack", {31'd0, a}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, d);
      v = pins & 16'hF0FF;
      chk($sformatf("R7 R8 read byte %0d", k), {24'd0, d}, {24'd0, (k % 2 == 0) ? v[7:0] : v[15:8]});
    end
    chk("R7 released after nack", {31'd0, sda_oe}, 32'd0);
    bus_stop();

    // R8 pin patterns with latch all ones
    bus_start();
    send_byte(8'h4A, a, b);
    write_pair(16'hFFFF, "R4");
    bus_stop();
    for (int k = 0; k < 6; k++) begin
      pins = 16'((k * 16'h6B3D) ^ (16'h8001 << k));
      bus_start();
      send_byte(8'h4B, a, b);
      recv_byte(1'b1, d);
      chk("R8 low byte", {24'd0, d}, {24'd0, pins[7:0]});
      recv_byte(1'b0, d);
      chk("R8 high byte", {24'd0, d}, {24'd0, pins[15:8]});
      bus_stop();
    end

    // R8 pins latched low read low against high input; R10 no boost for zeros
    bus_start();
    send_byte(8'h4A, a, b);
    write_pair(16'h0000, "R4");
    bus_stop();
    pins = 16'hFFFF;
    bus_start();
    send_byte(8'h4B, a, b);
    recv_byte(1'b1, d);
    chk("R8 forced low byte0", {24'd0, d}, 32'd0);
    recv_byte(1'b0, d);
    chk("R8 forced low byte1", {24'd0, d}, 32'd0);
    bus_stop();

    // R1 read to another address: bus stays high, latch untouched
    bus_start();
    send_byte(8'h43, a, b);
    chk("R1 foreign read ack", {31'd0, a}, 32'd0);
    recv_byte(1'b0, d);
    chk("R1 foreign read data", {24'd0, d}, 32'h000000FF);
    bus_stop();
    chk("R1 latch untouched", {16'd0, latch}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule